// File: doc/BRIEF.md
# Trap and privilege stack controller

This block holds the machine status state of a small in-order processor core. It tracks the current privilege level and interrupt enable, plus a stack of saved privilege and enable pairs (three levels by default). Each cycle it checks four interrupt pending lines against the current privilege and enable. It merges a winning interrupt with any synchronous exception the pipeline reports. When a trap is accepted, it pushes the stack, records the cause and the exception PC, and sends the fetch unit a redirect to a vector address scaled by the privilege that was active before the trap. A trap-return strobe pops the stack and redirects fetch to the saved exception PC.

A single write port sets the packed status word. Enable bits are always written. Privilege fields are written only when the value is a legal encoding. Every input is a single-cycle strobe or level sampled on the rising clock edge. Every event is accepted in the cycle it is presented, so the block has no back-pressure and carries no ready signals. The redirect is a one-cycle valid pulse that the fetch unit must consume when it appears. All results are registered and appear one cycle after the triggering edge.

Top module: `trap_stack_ctrl`

## Requirements
- R1: A trap copies level 1 into level 2 and the current pair into level 1. It then sets the current privilege to machine, clears the current enable and sets the memory-access privilege to machine.
- R2: A trap-return that is not overridden copies level 1 into the current pair and level 2 into level 1. It sets level 2 to privilege user with enable 1, and redirects to the stored exception PC.
- R3: The redirect address of a trap is 0x40 times the privilege encoding that was current before the trap (0x0, 0x40 or 0xC0).
- R4: A trap writes the cause register and writes the exception PC register with `inst_pc`. It raises `redirect_valid` for exactly the following cycle.
- R5: The machine software and host interrupts are taken only when the current privilege is below machine, or is machine with the enable set.
- R6: The supervisor software interrupt and the timer interrupt are taken only when the current privilege is user, or is supervisor with the enable set. The timer interrupt also requires the timer enable bit.
- R7: Interrupt priority is machine software, then host, then supervisor software, then timer. The cause is bit XLEN-1 set with the code in the low bits: software = 0, timer = 1, host = 2.
- R8: If an interrupt qualifies in the same cycle as a reported exception, the interrupt is taken and the exception is dropped.
- R9: A trap outranks a trap-return in the same cycle. A status write is ignored in any cycle that has a trap or a trap-return.
- R10: After reset the current privilege is machine and both saved privileges are supervisor. All enables are 0, the memory-access privilege is user, and cause and exception PC are 0. The redirect address is 0x100 and `redirect_valid` is low.
- R11: The status word layout is as follows. Bit 3k is the enable of level k, bits 3k+2:3k+1 are its privilege, bits 10:9 are the memory-access privilege and bit 11 is the timer enable. Privilege encodings are user = 0, supervisor = 1, machine = 3. A write stores enables unconditionally, and stores a privilege field only if it is not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Synchronous exception reported this cycle |
| exc_cause | input | XLEN | Cause code of the exception |
| inst_pc | input | XLEN | PC of the instruction at the commit point |
| ret_valid | input | 1 | Trap-return strobe |
| pend_msw | input | 1 | Machine software interrupt pending |
| pend_host | input | 1 | Host message pending |
| pend_ssw | input | 1 | Supervisor software interrupt pending |
| pend_timer | input | 1 | Timer interrupt pending |
| csr_wr_en | input | 1 | Status word write strobe |
| csr_wr_data | input | 3*LEVELS+3 | Status word write value |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | XLEN | Fetch redirect address |
| cur_priv | output | 2 | Current privilege |
| cur_ie | output | 1 | Current interrupt enable |
| status_o | output | 3*LEVELS+3 | Packed status word |
| cause_o | output | XLEN | Cause register |
| epc_o | output | XLEN | Exception PC register |

## Verification
The bench targets the gating boundaries. These are a supervisor with interrupts off and pending supervisor-class lines, a machine with interrupts off and every line pending, and a pending timer with its enable clear. A design with the comparisons wrong would trap repeatedly or never leave user code. It also drives collisions in a single cycle: exception with interrupt, trap with return, and writes carrying the illegal privilege value 2. A wrong priority would record the wrong cause or corrupt the stack, and a missing legality check would leave an unusable privilege in place. Push and pop sequences across all three levels expose a stack that shifts the wrong way or fails to refill its top with user and enable 1.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // One stack level: privilege in the upper two bits, enable in bit 0.
  typedef struct packed {
    priv_e priv;
    logic  ie;
  } lvl_t;

  localparam int IRQ_SRCS   = 4;
  localparam int IRQ_CODE_W = 2;
  localparam logic [IRQ_CODE_W-1:0] CODE_SW    = 2'd0;
  localparam logic [IRQ_CODE_W-1:0] CODE_TIMER = 2'd1;
  localparam logic [IRQ_CODE_W-1:0] CODE_HOST  = 2'd2;

  function automatic logic priv_legal(input logic [1:0] p);
    return p != 2'd2;
  endfunction
endpackage

// File: rtl/tsc_irq_arb.sv
module tsc_irq_arb
  import tsc_pkg::*;
(
  input  priv_e                 cur_priv,
  input  logic                  cur_ie,
  input  logic                  timer_en,
  input  logic                  pend_msw,
  input  logic                  pend_host,
  input  logic                  pend_ssw,
  input  logic                  pend_timer,
  output logic                  irq_go,
  output logic [IRQ_CODE_W-1:0] irq_code
);
  localparam logic [IRQ_CODE_W-1:0] SRC_CODE [IRQ_SRCS] =
    '{CODE_SW, CODE_HOST, CODE_SW, CODE_TIMER};

  logic                m_open, s_open;
  logic [IRQ_SRCS-1:0] req;

  assign m_open = (cur_priv < PRIV_M) || cur_ie;
  assign s_open = (cur_priv < PRIV_S) || ((cur_priv == PRIV_S) && cur_ie);

  // Index order is priority order: 0 wins.
  assign req[0] = pend_msw  && m_open;
  assign req[1] = pend_host && m_open;
  assign req[2] = pend_ssw  && s_open;
  assign req[3] = pend_timer && timer_en && s_open;

  always_comb begin
    irq_go   = 1'b0;
    irq_code = '0;
    for (int i = IRQ_SRCS - 1; i >= 0; i--) begin
      if (req[i]) begin
        irq_go   = 1'b1;
        irq_code = SRC_CODE[i];
      end
    end
  end
endmodule

// File: rtl/tsc_priv_stack.sv
module tsc_priv_stack
  import tsc_pkg::*;
#(
  parameter int LEVELS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic                  pop,
  input  logic                  wr_en,
  input  logic [3*LEVELS+2:0]   wr_data,
  output logic [3*LEVELS+2:0]   status_o,
  output priv_e                 cur_priv,
  output logic                  cur_ie,
  output logic                  timer_en
);
  localparam int MPRV_LSB = 3 * LEVELS;
  localparam int TIE_BIT  = 3 * LEVELS + 2;

  lvl_t  lvl_q [LEVELS];
  priv_e mprv_q;
  logic  tie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LEVELS; i++) begin
        lvl_q[i].priv <= (i == 0) ? PRIV_M : PRIV_S;
        lvl_q[i].ie   <= 1'b0;
      end
      mprv_q <= PRIV_U;
      tie_q  <= 1'b0;
    end else if (push) begin
      lvl_q[0].priv <= PRIV_M;
      lvl_q[0].ie   <= 1'b0;
      for (int i = 1; i < LEVELS; i++) lvl_q[i] <= lvl_q[i-1];
      mprv_q <= PRIV_M;
    end else if (pop) begin
      for (int i = 0; i < LEVELS - 1; i++) lvl_q[i] <= lvl_q[i+1];
      lvl_q[LEVELS-1].priv <= PRIV_U;
      lvl_q[LEVELS-1].ie   <= 1'b1;
    end else if (wr_en) begin
      for (int i = 0; i < LEVELS; i++) begin
        lvl_q[i].ie <= wr_data[3*i];
        if (priv_legal(wr_data[3*i+1 +: 2]))
          lvl_q[i].priv <= priv_e'(wr_data[3*i+1 +: 2]);
      end
      if (priv_legal(wr_data[MPRV_LSB +: 2]))
        mprv_q <= priv_e'(wr_data[MPRV_LSB +: 2]);
      tie_q <= wr_data[TIE_BIT];
    end
  end

  for (genvar g = 0; g < LEVELS; g++) begin : g_pack
    assign status_o[3*g +: 3] = lvl_q[g];
  end
  assign status_o[MPRV_LSB +: 2] = mprv_q;
  assign status_o[TIE_BIT]       = tie_q;

  assign cur_priv = lvl_q[0].priv;
  assign cur_ie   = lvl_q[0].ie;
  assign timer_en = tie_q;
endmodule

// File: rtl/tsc_trap_regs.sv
module tsc_trap_regs #(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_PC  = 32'h100,
  parameter int          VEC_SHIFT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_trap,
  input  logic            take_ret,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [1:0]      prior_priv,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] redirect_pc,
  output logic            redirect_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q        <= '0;
      epc_q          <= '0;
      redirect_pc    <= XLEN'(RESET_PC);
      redirect_valid <= 1'b0;
    end else if (take_trap) begin
      cause_q        <= trap_cause;
      epc_q          <= trap_pc;
      redirect_pc    <= XLEN'(prior_priv) << VEC_SHIFT;
      redirect_valid <= 1'b1;
    end else if (take_ret) begin
      redirect_pc    <= epc_q;
      redirect_valid <= 1'b1;
    end else begin
      redirect_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_stack_ctrl.sv
module trap_stack_ctrl
  import tsc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          LEVELS    = 3,
  parameter logic [31:0] RESET_PC  = 32'h100,
  parameter int          VEC_SHIFT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_valid,
  input  logic [XLEN-1:0]     exc_cause,
  input  logic [XLEN-1:0]     inst_pc,
  input  logic                ret_valid,
  input  logic                pend_msw,
  input  logic                pend_host,
  input  logic                pend_ssw,
  input  logic                pend_timer,
  input  logic                csr_wr_en,
  input  logic [3*LEVELS+2:0] csr_wr_data,
  output logic                redirect_valid,
  output logic [XLEN-1:0]     redirect_pc,
  output logic [1:0]          cur_priv,
  output logic                cur_ie,
  output logic [3*LEVELS+2:0] status_o,
  output logic [XLEN-1:0]     cause_o,
  output logic [XLEN-1:0]     epc_o
);
  priv_e                 priv_now;
  logic                  ie_now, timer_en;
  logic                  irq_go, trap_go, ret_go, wr_go;
  logic [IRQ_CODE_W-1:0] irq_code;
  logic [XLEN-1:0]       trap_cause;

  tsc_irq_arb u_arb (
    .cur_priv   (priv_now),
    .cur_ie     (ie_now),
    .timer_en   (timer_en),
    .pend_msw   (pend_msw),
    .pend_host  (pend_host),
    .pend_ssw   (pend_ssw),
    .pend_timer (pend_timer),
    .irq_go     (irq_go),
    .irq_code   (irq_code)
  );

  // Interrupt beats exception; any trap beats return; writes lose to both.
  assign trap_go    = irq_go || exc_valid;
  assign ret_go     = ret_valid && !trap_go;
  assign wr_go      = csr_wr_en && !trap_go && !ret_valid;
  assign trap_cause = irq_go ? {1'b1, {(XLEN-1-IRQ_CODE_W){1'b0}}, irq_code} : exc_cause;

  tsc_priv_stack #(.LEVELS(LEVELS)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (trap_go),
    .pop      (ret_go),
    .wr_en    (wr_go),
    .wr_data  (csr_wr_data),
    .status_o (status_o),
    .cur_priv (priv_now),
    .cur_ie   (ie_now),
    .timer_en (timer_en)
  );

  tsc_trap_regs #(
    .XLEN(XLEN), .RESET_PC(RESET_PC), .VEC_SHIFT(VEC_SHIFT)
  ) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .take_trap      (trap_go),
    .take_ret       (ret_go),
    .trap_cause     (trap_cause),
    .trap_pc        (inst_pc),
    .prior_priv     (priv_now),
    .cause_q        (cause_o),
    .epc_q          (epc_o),
    .redirect_pc    (redirect_pc),
    .redirect_valid (redirect_valid)
  );

  assign cur_priv = priv_now;
  assign cur_ie   = ie_now;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int XLEN   = 32,
  parameter int LEVELS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trap_go,
  input logic                irq_go,
  input logic                ret_valid,
  input logic [XLEN-1:0]     inst_pc,
  input logic [3*LEVELS+2:0] status_o,
  input logic                redirect_valid,
  input logic [XLEN-1:0]     redirect_pc,
  input logic [XLEN-1:0]     epc_o
);
  localparam int TOP = 3 * LEVELS - 1;
  localparam int MP  = 3 * LEVELS;

  AST_TRAP_ENTERS_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> status_o[2:0] == 3'b110); // R1
  AST_TRAP_SAVES_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> status_o[5:3] == $past(status_o[2:0])); // R1
  AST_RET_REFILLS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !trap_go) |=> status_o[TOP -: 3] == 3'b001); // R2
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> redirect_valid && redirect_pc == (XLEN'($past(status_o[2:1])) << 6)); // R3
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> epc_o == $past(inst_pc)); // R4
  AST_MACHINE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_go && status_o[2:1] == 2'b11) |-> status_o[0]); // R5
  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[2:1] != 2'b10 && status_o[MP +: 2] != 2'b10); // R11
endmodule

bind trap_stack_ctrl tsc_checker #(.XLEN(XLEN), .LEVELS(LEVELS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .trap_go        (trap_go),
  .irq_go         (irq_go),
  .ret_valid      (ret_valid),
  .inst_pc        (inst_pc),
  .status_o       (status_o),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .epc_o          (epc_o)
);

// File: tb/trap_stack_ctrl_tb_top.sv
module trap_stack_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  function automatic logic [11:0] st(input logic [1:0] p0, input logic i0,
      input logic [1:0] p1, input logic i1, input logic [1:0] p2, input logic i2,
      input logic [1:0] mp, input logic tie);
    return {tie, mp, p2, i2, p1, i1, p0, i0};
  endfunction

  // op: 0 idle/irq only, 1 status write, 2 exception, 3 return, 4 exception+return
  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  irq;     // {msw, host, ssw, timer}
    logic [11:0] wdata;
    logic [31:0] cause;
    logic [31:0] pc;
    logic [11:0] est;
    logic        erv;
    logic [31:0] eredir;
    logic [31:0] ecause;
    logic [31:0] eepc;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd1, 4'b0000, st(0,1,1,0,1,0,0,0), 32'd0, 32'h0,    st(0,1,1,0,1,0,0,0), 1'b0, 32'h100,  32'h0,        32'h0},
    '{3'd2, 4'b0000, 12'h0,               32'd5, 32'h1000, st(3,0,0,1,1,0,3,0), 1'b1, 32'h0,    32'h5,        32'h1000},
    '{3'd3, 4'b0000, 12'h0,               32'd0, 32'h0,    st(0,1,1,0,0,1,3,0), 1'b1, 32'h1000, 32'h5,        32'h1000},
    '{3'd0, 4'b0001, 12'h0,               32'd0, 32'h2000, st(0,1,1,0,0,1,3,0), 1'b0, 32'h1000, 32'h5,        32'h1000},
    '{3'd1, 4'b0000, st(2,1,2,1,0,0,2,1), 32'd0, 32'h0,    st(0,1,1,1,0,0,3,1), 1'b0, 32'h1000, 32'h5,        32'h1000},
    '{3'd0, 4'b1111, 12'h0,               32'd0, 32'h2100, st(3,0,0,1,1,1,3,1), 1'b1, 32'h0,    32'h80000000, 32'h2100},
    '{3'd0, 4'b1111, 12'h0,               32'd0, 32'h2200, st(3,0,0,1,1,1,3,1), 1'b0, 32'h0,    32'h80000000, 32'h2100},
    '{3'd1, 4'b0000, st(1,0,0,1,1,1,3,1), 32'd0, 32'h0,    st(1,0,0,1,1,1,3,1), 1'b0, 32'h0,    32'h80000000, 32'h2100},
    '{3'd0, 4'b0111, 12'h0,               32'd0, 32'h3000, st(3,0,1,0,0,1,3,1), 1'b1, 32'h40,   32'h80000002, 32'h3000},
    '{3'd3, 4'b0000, 12'h0,               32'd0, 32'h0,    st(1,0,0,1,0,1,3,1), 1'b1, 32'h3000, 32'h80000002, 32'h3000},
    '{3'd0, 4'b0011, 12'h0,               32'd0, 32'h3050, st(1,0,0,1,0,1,3,1), 1'b0, 32'h3000, 32'h80000002, 32'h3000},
    '{3'd1, 4'b0000, st(1,1,0,1,0,1,3,1), 32'd0, 32'h0,    st(1,1,0,1,0,1,3,1), 1'b0, 32'h3000, 32'h80000002, 32'h3000},
    '{3'd0, 4'b0001, 12'h0,               32'd0, 32'h3100, st(3,0,1,1,0,1,3,1), 1'b1, 32'h40,   32'h80000001, 32'h3100},
    '{3'd4, 4'b0000, 12'h0,               32'd7, 32'h4000, st(3,0,3,0,1,1,3,1), 1'b1, 32'hC0,   32'h7,        32'h4000},
    '{3'd2, 4'b1000, 12'h0,               32'd3, 32'h4100, st(3,0,3,0,3,0,3,1), 1'b1, 32'hC0,   32'h3,        32'h4100},
    '{3'd3, 4'b0000, 12'h0,               32'd0, 32'h0,    st(3,0,3,0,0,1,3,1), 1'b1, 32'h4100, 32'h3,        32'h4100},
    '{3'd1, 4'b0000, st(0,1,3,0,0,1,3,1), 32'd0, 32'h0,    st(0,1,3,0,0,1,3,1), 1'b0, 32'h4100, 32'h3,        32'h4100},
    '{3'd2, 4'b0010, 12'h0,               32'd2, 32'h5000, st(3,0,0,1,3,0,3,1), 1'b1, 32'h0,    32'h80000000, 32'h5000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0, ret_valid = 1'b0, csr_wr_en = 1'b0;
  logic        pend_msw = 1'b0, pend_host = 1'b0, pend_ssw = 1'b0, pend_timer = 1'b0;
  logic [31:0] exc_cause = '0, inst_pc = '0;
  logic [11:0] csr_wr_data = '0;
  logic        redirect_valid, cur_ie;
  logic [31:0] redirect_pc, cause_o, epc_o;
  logic [1:0]  cur_priv;
  logic [11:0] status_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_stack_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .inst_pc(inst_pc), .ret_valid(ret_valid), .pend_msw(pend_msw),
    .pend_host(pend_host), .pend_ssw(pend_ssw), .pend_timer(pend_timer),
    .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .cur_priv(cur_priv), .cur_ie(cur_ie), .status_o(status_o),
    .cause_o(cause_o), .epc_o(epc_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check_reset_state();
    chk("R10", "status", 32'(status_o), 32'(st(3,0,1,0,1,0,0,0)));
    chk("R10", "redirect_pc", redirect_pc, 32'h100);
    chk("R10", "redirect_valid", 32'(redirect_valid), 32'd0);
    chk("R10", "cause", cause_o, 32'h0);
    chk("R10", "epc", epc_o, 32'h0);
    chk("R10", "cur_priv", 32'(cur_priv), 32'd3);
    chk("R10", "cur_ie", 32'(cur_ie), 32'd0);
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.op == 3'd4) return "R9";
    if (v.op == 3'd2 && v.irq != 4'b0000) return "R8";
    case (v.op)
      3'd1: return "R11";
      3'd2: return "R1 R3 R4";
      3'd3: return "R2";
      default: return (v.erv ? "R7" : "R5 R6");
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      csr_wr_en   = (VECS[i].op == 3'd1);
      csr_wr_data = VECS[i].wdata;
      exc_valid   = (VECS[i].op == 3'd2) || (VECS[i].op == 3'd4);
      ret_valid   = (VECS[i].op == 3'd3) || (VECS[i].op == 3'd4);
      exc_cause   = VECS[i].cause;
      inst_pc     = VECS[i].pc;
      {pend_msw, pend_host, pend_ssw, pend_timer} = VECS[i].irq;
      @(negedge clk);
      csr_wr_en = 1'b0; exc_valid = 1'b0; ret_valid = 1'b0;
      {pend_msw, pend_host, pend_ssw, pend_timer} = 4'b0000;
      chk(tag_of(VECS[i]), $sformatf("v%0d status", i), 32'(status_o), 32'(VECS[i].est));
      chk(tag_of(VECS[i]), $sformatf("v%0d redirect_valid", i), 32'(redirect_valid), 32'(VECS[i].erv));
      chk(tag_of(VECS[i]), $sformatf("v%0d redirect_pc", i), redirect_pc, VECS[i].eredir);
      chk(tag_of(VECS[i]), $sformatf("v%0d cause", i), cause_o, VECS[i].ecause);
      chk(tag_of(VECS[i]), $sformatf("v%0d epc", i), epc_o, VECS[i].eepc);
      chk("R11", $sformatf("v%0d cur_priv", i), 32'(cur_priv), 32'(VECS[i].est[2:1]));
      chk("R11", $sformatf("v%0d cur_ie", i), 32'(cur_ie), 32'(VECS[i].est[0]));
    end

    // R4: the redirect pulse lasts a single cycle.
    @(negedge clk);
    chk("R4", "redirect_valid drops", 32'(redirect_valid), 32'd0);

    // R10: reset in mid-run restores the initial state.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    finish_run();
  end
endmodule